// File: doc/BRIEF.md
# Load Store-Dependency Scanner

When a load issues, this block looks through the circular load/store queue for a store that the load depends on. It starts at the slot just older than the load and moves back toward the queue head. The first store it finds that conflicts with the load decides the answer, so the nearest older store always wins.

A store conflicts with the load in either of two cases:
- Its address is known and its byte range overlaps the load's byte range.
- Its address is still unknown and the aliasing-prediction input for this load is high.

The block returns one of three answers:
- No dependency.
- Forward: the store's data is ready, so its bytes can be forwarded.
- Wait: the load must return to the dispatched state. The answer names the blocking store's tag as an extra source operand and raises a replay request.

When a replayed load issues again, the scan is repeated. A flag reports when the store that now conflicts differs from the one recorded at the previous attempt. A saturating counter counts the replays of the current load.

The queue contents come in as flat per-entry vectors: valid, is-store, address known, data ready, address, and size code. The scheduler pulses `issueValid` with the load's slot, the head slot, the load's address, the load's size and the prediction bit. It sets `reissue` when this is a repeat attempt of the same load. The answer appears on the registered outputs in the next cycle.

Top module: `store_dep_scan`

## Requirements
- R1: While reset is held, and after reset until the first issue, `respValid` is 0, `respKind` is 0 and `replayCount` is 0.
- R2: Every cycle in which `issueValid` is 1 produces `respValid` = 1 in exactly the following cycle, and `respValid` is 0 in all other cycles.
- R3: The scan only looks at the slots that are strictly older than the load.
  - These are the slots from `loadIdx`-1 back to `headIdx`, counted modulo DEPTH, so the window may wrap past the last slot.
  - When `loadIdx` equals `headIdx`, no slot is older and the answer is "no dependency".
  - Slots outside the window have no effect.
- R4: When several slots conflict, the one nearest to the load in age wins, and `respTag` is that slot's index.
- R5: A slot conflicts by address when all of the following hold:
  - It is valid, it is a store, and its address is known.
  - The half-open range [addr, addr+bytes) overlaps the load's range, where size code 0, 1, 2, 3 means 1, 2, 4, 8 bytes.
  - Ranges that only touch end to start do not overlap.
  - Invalid slots and non-store slots never conflict.
- R6: A valid store whose address is not yet known conflicts only when `aliasPred` is 1; otherwise the load scans past it.
- R7: `respKind` encodes the answer:
  - 0 means no conflict.
  - 1 (forward) means the winner's address is known and its data is ready.
  - 2 (wait) covers every other winner.
  - `replayReq` is 1 exactly when `respKind` is 2.
- R8: On a response to an attempt with `reissue` = 1, `matchChanged` is 1 when a conflict was found and either the previous attempt found none or it found a different tag. `matchChanged` is 0 on a first issue.
- R9: `replayCount` follows the load's replays:
  - A first issue sets it to 1 if the answer is wait and to 0 otherwise.
  - A reissue with a wait answer adds 1, saturating at all ones.
  - Any other reissue leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Load issue strobe |
| reissue | input | 1 | This attempt repeats the previous load after a replay |
| loadIdx | input | IDXW | Queue slot of the load |
| headIdx | input | IDXW | Queue slot of the oldest entry |
| loadAddr | input | AW | Load byte address |
| loadSize | input | 2 | Load size code (bytes = 1 << code) |
| aliasPred | input | 1 | Prediction that this load aliases unknown store addresses |
| entValid | input | DEPTH | Per-slot valid |
| entStore | input | DEPTH | Per-slot is-store |
| entAddrOk | input | DEPTH | Per-slot address known |
| entDataOk | input | DEPTH | Per-slot store data ready |
| entAddr | input | DEPTH*AW | Per-slot address, slot e at bits e*AW upward |
| entSize | input | DEPTH*2 | Per-slot size code, slot e at bits 2e upward |
| respValid | output | 1 | Response valid |
| respKind | output | 2 | 0 none, 1 forward, 2 wait |
| respTag | output | IDXW | Slot index of the winning store |
| replayReq | output | 1 | Load must replay |
| matchChanged | output | 1 | Reissue found a different store |
| replayCount | output | CNTW | Replays of the current load |

## Verification
Random queues are packed into a 32-byte address span with mixed sizes. This makes overlaps, near misses and multiple candidates common, and it separates the choice of the nearest older store from the choice of any other conflicting store. Random head and load slots exercise windows that wrap and windows that do not, including the empty window.

Directed cases cover the following:
- Adjacent ranges that must not conflict.
- An unknown-address store with the prediction off and then on, which separates scanning past the store from waiting on it.
- An older overlapping store placed just outside the window.
- Reissue chains in which the blocking store moves or stays. These separate a changed match from a repeated one and drive the replay counter to saturation.

// File: rtl/store_dep_pkg.sv
package store_dep_pkg;

  typedef enum logic [1:0] {
    DEP_NONE = 2'd0,
    DEP_FWD  = 2'd1,
    DEP_WAIT = 2'd2
  } depKind_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } dpStrobe_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/store_dep_dp.sv
module store_dep_dp
  import store_dep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [IDXW-1:0]     loadIdx,
  input  logic [IDXW-1:0]     headIdx,
  input  logic [AW-1:0]       loadAddr,
  input  logic [1:0]          loadSize,
  input  logic                aliasPred,
  input  logic [DEPTH-1:0]    entValid,
  input  logic [DEPTH-1:0]    entStore,
  input  logic [DEPTH-1:0]    entAddrOk,
  input  logic [DEPTH-1:0]    entDataOk,
  input  logic [DEPTH*AW-1:0] entAddr,
  input  logic [DEPTH*2-1:0]  entSize,
  output logic                scanHit,
  output logic                scanWait,
  output logic [IDXW-1:0]     scanTag,
  output depKind_t            respKind,
  output logic [IDXW-1:0]     respTag
);

  logic [AW:0]       loadStart, loadEnd;
  logic [DEPTH-1:0]  conflict;
  logic [IDXW-1:0]   olderCnt;

  assign loadStart = {1'b0, loadAddr};
  assign loadEnd   = loadStart + (AW+1)'(sizeBytes(loadSize));
  assign olderCnt  = loadIdx - headIdx;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [AW:0] slotStart, slotEnd;
    logic        overlap;
    assign slotStart = {1'b0, entAddr[e*AW +: AW]};
    assign slotEnd   = slotStart + (AW+1)'(sizeBytes(entSize[e*2 +: 2]));
    assign overlap   = (loadStart < slotEnd) && (slotStart < loadEnd);
    assign conflict[e] = entValid[e] && entStore[e] &&
                         (entAddrOk[e] ? overlap : aliasPred);
  end

  // Walk from the farthest older slot toward the load so the nearest one is assigned last.
  always_comb begin
    logic [IDXW-1:0] idx;
    scanHit  = 1'b0;
    scanWait = 1'b0;
    scanTag  = '0;
    for (int d = DEPTH-1; d >= 1; d--) begin
      idx = loadIdx - IDXW'(d);
      if ((d <= int'(olderCnt)) && conflict[idx]) begin
        scanHit  = 1'b1;
        scanTag  = idx;
        scanWait = !(entAddrOk[idx] && entDataOk[idx]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respKind <= DEP_NONE;
      respTag  <= '0;
    end else if (strobe.capture) begin
      respKind <= !scanHit ? DEP_NONE : (scanWait ? DEP_WAIT : DEP_FWD);
      respTag  <= scanTag;
    end else if (strobe.clear) begin
      respKind <= DEP_NONE;
      respTag  <= '0;
    end
  end

endmodule

// File: rtl/store_dep_ctrl.sv
module store_dep_ctrl
  import store_dep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNTW  = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic            reissue,
  input  logic            scanHit,
  input  logic            scanWait,
  input  logic [IDXW-1:0] scanTag,
  output dpStrobe_t       strobe,
  output logic            respValid,
  output logic            matchChanged,
  output logic [CNTW-1:0] replayCount
);

  logic            savedHit;
  logic [IDXW-1:0] savedTag;

  assign strobe.capture = issueValid;
  assign strobe.clear   = !issueValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      matchChanged <= 1'b0;
      replayCount  <= '0;
      savedHit     <= 1'b0;
      savedTag     <= '0;
    end else if (issueValid) begin
      respValid <= 1'b1;
      savedHit  <= scanHit;
      savedTag  <= scanTag;
      if (reissue) begin
        matchChanged <= scanHit && (!savedHit || (scanTag != savedTag));
        if (scanWait && (replayCount != {CNTW{1'b1}}))
          replayCount <= replayCount + 1'b1;
      end else begin
        matchChanged <= 1'b0;
        replayCount  <= scanWait ? CNTW'(1) : '0;
      end
    end else begin
      respValid    <= 1'b0;
      matchChanged <= 1'b0;
    end
  end

endmodule

// File: rtl/store_dep_scan.sv
module store_dep_scan
  import store_dep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int CNTW  = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic                reissue,
  input  logic [IDXW-1:0]     loadIdx,
  input  logic [IDXW-1:0]     headIdx,
  input  logic [AW-1:0]       loadAddr,
  input  logic [1:0]          loadSize,
  input  logic                aliasPred,
  input  logic [DEPTH-1:0]    entValid,
  input  logic [DEPTH-1:0]    entStore,
  input  logic [DEPTH-1:0]    entAddrOk,
  input  logic [DEPTH-1:0]    entDataOk,
  input  logic [DEPTH*AW-1:0] entAddr,
  input  logic [DEPTH*2-1:0]  entSize,
  output logic                respValid,
  output logic [1:0]          respKind,
  output logic [IDXW-1:0]     respTag,
  output logic                replayReq,
  output logic                matchChanged,
  output logic [CNTW-1:0]     replayCount
);

  dpStrobe_t       strobe;
  logic            scanHit, scanWait;
  logic [IDXW-1:0] scanTag;
  depKind_t        kindQ;

  store_dep_dp #(.DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadIdx(loadIdx), .headIdx(headIdx), .loadAddr(loadAddr),
    .loadSize(loadSize), .aliasPred(aliasPred),
    .entValid(entValid), .entStore(entStore), .entAddrOk(entAddrOk),
    .entDataOk(entDataOk), .entAddr(entAddr), .entSize(entSize),
    .scanHit(scanHit), .scanWait(scanWait), .scanTag(scanTag),
    .respKind(kindQ), .respTag(respTag)
  );

  store_dep_ctrl #(.DEPTH(DEPTH), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .reissue(reissue),
    .scanHit(scanHit), .scanWait(scanWait), .scanTag(scanTag),
    .strobe(strobe), .respValid(respValid), .matchChanged(matchChanged),
    .replayCount(replayCount)
  );

  assign respKind  = kindQ;
  assign replayReq = (kindQ == DEP_WAIT);

endmodule

// File: rtl/store_dep_chk.sv
module store_dep_chk #(
  parameter int DEPTH = 16,
  parameter int CNTW  = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             reissue,
  input logic [IDXW-1:0]  loadIdx,
  input logic [IDXW-1:0]  headIdx,
  input logic [DEPTH-1:0] entDataOk,
  input logic             respValid,
  input logic [1:0]       respKind,
  input logic [IDXW-1:0]  respTag,
  input logic             matchChanged,
  input logic [CNTW-1:0]  replayCount
);

  // R2
  resp_follows_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(issueValid));

  // R1
  idle_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respKind != 2'd0) |-> respValid);

  // R3
  empty_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(loadIdx == headIdx)) |-> (respKind == 2'd0));

  // R7
  fwd_data_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respKind == 2'd1) |-> (($past(entDataOk) >> respTag) & 1) != 0);

  // R8
  change_on_reissue_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchChanged |-> (respValid && $past(reissue)));

  // R9
  count_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !$past(reissue)) |-> (replayCount == ((respKind == 2'd2) ? CNTW'(1) : CNTW'(0))));

  // R9
  count_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(reissue) && respKind == 2'd2 && $past(replayCount) != {CNTW{1'b1}})
      |-> (replayCount == CNTW'($past(replayCount) + 1'b1)));

endmodule

bind store_dep_scan store_dep_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .reissue(reissue),
  .loadIdx(loadIdx), .headIdx(headIdx), .entDataOk(entDataOk),
  .respValid(respValid), .respKind(respKind), .respTag(respTag),
  .matchChanged(matchChanged), .replayCount(replayCount)
);

// File: tb/store_dep_scan_tb.sv
`timescale 1ns/100ps
module store_dep_scan_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 16;
  localparam int CNTW  = 4;
  localparam int IDXW  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, reissue = 1'b0, aliasPred = 1'b0;
  logic [IDXW-1:0] loadIdx = '0, headIdx = '0;
  logic [AW-1:0] loadAddr = '0;
  logic [1:0] loadSize = '0;
  logic [DEPTH-1:0] entValid = '0, entStore = '0, entAddrOk = '0, entDataOk = '0;
  logic [DEPTH*AW-1:0] entAddr;
  logic [DEPTH*2-1:0] entSize;
  logic [AW-1:0] bAddr [DEPTH];
  logic [1:0] bSize [DEPTH];

  logic respValid, replayReq, matchChanged;
  logic [1:0] respKind;
  logic [IDXW-1:0] respTag;
  logic [CNTW-1:0] replayCount;

  int checks = 0, fails = 0;
  bit mHit = 0; int mTag = 0; int mCnt = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      entAddr[e*AW +: AW] = bAddr[e];
      entSize[e*2 +: 2]   = bSize[e];
    end
  end

  store_dep_scan #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .reissue(reissue),
    .loadIdx(loadIdx), .headIdx(headIdx), .loadAddr(loadAddr), .loadSize(loadSize),
    .aliasPred(aliasPred), .entValid(entValid), .entStore(entStore),
    .entAddrOk(entAddrOk), .entDataOk(entDataOk), .entAddr(entAddr), .entSize(entSize),
    .respValid(respValid), .respKind(respKind), .respTag(respTag),
    .replayReq(replayReq), .matchChanged(matchChanged), .replayCount(replayCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit conflictAt(input int p);
    int ls, le, ss, se;
    if (!(entValid[p] && entStore[p])) return 0;
    if (!entAddrOk[p]) return aliasPred;
    ls = int'(loadAddr); le = ls + (1 << loadSize);
    ss = int'(bAddr[p]); se = ss + (1 << bSize[p]);
    return (ls < se) && (ss < le);
  endfunction

  task automatic setEntry(input int i, input bit v, input bit st, input bit ar,
                          input bit dr, input int a, input int sz);
    entValid[i] = v; entStore[i] = st; entAddrOk[i] = ar; entDataOk[i] = dr;
    bAddr[i] = AW'(a); bSize[i] = 2'(sz);
  endtask

  task automatic clearQueue();
    for (int i = 0; i < DEPTH; i++) setEntry(i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doIssue(input bit re);
    bit hit, wt; int tag, p, expKind, expChg;
    hit = 0; wt = 0; tag = 0; p = int'(loadIdx);
    while (p != int'(headIdx)) begin
      p = (p + DEPTH - 1) % DEPTH;
      if (conflictAt(p)) begin
        hit = 1; tag = p; wt = !(entAddrOk[p] && entDataOk[p]);
        break;
      end
    end
    expKind = !hit ? 0 : (wt ? 2 : 1);
    expChg = re && hit && (!mHit || tag != mTag);
    if (!re) mCnt = wt ? 1 : 0;
    else if (wt && mCnt != 15) mCnt++;
    mHit = hit; mTag = tag;
    reissue = re; issueValid = 1'b1;
    @(posedge clk); @(negedge clk);
    issueValid = 1'b0;
    check("R2 respValid", respValid, 1);
    check("R4/R5/R6 respKind", respKind, expKind);
    if (hit) check("R4 respTag", respTag, tag);
    check("R7 replayReq", replayReq, expKind == 2);
    check("R8 matchChanged", matchChanged, expChg);
    check("R9 replayCount", replayCount, mCnt);
    @(negedge clk);
    check("R2 respValid drop", respValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clearQueue();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 respValid", respValid, 0);
    check("R1 respKind", respKind, 0);
    check("R1 replayCount", replayCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", respValid, 0);

    // R3 empty window: overlapping store elsewhere is ignored
    setEntry(5, 1, 1, 1, 1, 100, 2);
    headIdx = 4'd7; loadIdx = 4'd7; loadAddr = 100; loadSize = 2;
    doIssue(0);

    // R3 wraparound window 14,15,0; slot 3 outside
    clearQueue();
    headIdx = 4'd14; loadIdx = 4'd1; loadAddr = 40; loadSize = 3;
    setEntry(3, 1, 1, 1, 1, 40, 3);
    setEntry(15, 1, 1, 1, 1, 44, 2);
    doIssue(0);
    // R4 nearest older (slot 0) wins over 15
    setEntry(0, 1, 1, 1, 0, 47, 0);
    doIssue(0);

    // R5 adjacent ranges do not overlap; non-store ignored
    clearQueue();
    headIdx = 4'd0; loadIdx = 4'd4; loadAddr = 12; loadSize = 2;
    setEntry(1, 1, 1, 1, 1, 8, 2);
    setEntry(2, 1, 1, 1, 1, 16, 3);
    setEntry(3, 1, 0, 1, 1, 12, 2);
    doIssue(0);

    // R6 unknown address: pred off passes, pred on waits
    setEntry(2, 1, 1, 0, 0, 500, 0);
    aliasPred = 0; doIssue(0);
    aliasPred = 1; doIssue(0);

    // R8/R9 reissue chain: new store appears younger, then stays
    aliasPred = 0;
    setEntry(2, 1, 1, 1, 0, 12, 1);
    doIssue(0);
    setEntry(3, 1, 1, 1, 0, 13, 0);
    doIssue(1);
    for (int k = 0; k < 16; k++) doIssue(1);
    setEntry(3, 1, 1, 1, 1, 13, 0);
    doIssue(1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < DEPTH; i++)
        setEntry(i, $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1), $urandom_range(0, 31), $urandom_range(0, 3));
      headIdx = IDXW'($urandom_range(0, 15));
      loadIdx = IDXW'($urandom_range(0, 15));
      loadAddr = AW'($urandom_range(0, 31));
      loadSize = 2'($urandom_range(0, 3));
      aliasPred = $urandom_range(0, 1);
      doIssue(n != 0 && $urandom_range(0, 9) < 4);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule